// File: doc/BRIEF.md
# Masked Alarm and Interrupt Pin Generator

This block sits next to a BCD time-of-day counter. Four alarm registers hold a seconds, minutes, hours and date value. Each register also carries one mask bit in its top position. The four mask bits together set how often the alarm fires: every second, on a seconds match, or on progressively wider matches up to a full date-and-time match. Any mask combination that is not a defined rate falls back to firing every second. Matching is evaluated only on the clock cycle that carries the 1 Hz tick, by which point the time fields already hold the new second.

A match always sets the alarm flag. The flag drives the shared active-low interrupt pin only when the alarm enable is set. In battery-backup mode the pin also needs the backup enable. A host access to the flags register releases the alarm drive while the access is in progress. The flag is cleared on the clock edge that follows the end of that access. An external watchdog interrupt also pulls the pin low. When the frequency-test conditions hold, the pin instead follows a 512 Hz square wave. While in battery mode, the host bus is ignored.

Top module: `alarm_irq_gen`

## Requirements
- R1: Synchronous reset clears the alarm enable, the backup enable, the alarm flag and all four alarm registers, and leaves irq_n at 1.
- R2: The alarm registers at addresses 2 (seconds), 3 (minutes), 4 (hours) and 5 (date) and the enable register at address 6 are fully readable and writable bytes. In the enable register, bit 7 is the alarm enable and bit 5 is the backup enable. Addresses 1 and 7 to 15 read 0.
- R3: Bit 7 of registers 5, 4, 3 and 2 form the mask {date, hour, min, sec}. The legal patterns behave as follows:
  - 1111 fires on every tick.
  - 1110 fires when seconds match.
  - 1100 fires when minutes and seconds match.
  - 1000 fires when hours, minutes and seconds match.
  - 0000 fires when date and all time fields match.
  
  Seconds and minutes compare bits 6:0. Hours and date compare bits 5:0.
- R4: Every other mask pattern fires on every tick.
- R5: The alarm flag is set only on a clock edge at which tick_1hz is high.
- R6: A match sets the alarm flag even when the alarm enable is 0, and irq_n then stays 1.
- R7: Outside battery mode, with no flags access in progress, irq_n is 0 whenever the alarm flag and the alarm enable are both 1.
- R8: In battery mode, the alarm drives irq_n low only when both the alarm enable and the backup enable are 1.
- R9: While the flags register (address 0) is being accessed, and until the clock edge after the access ends, the alarm does not drive irq_n. The flag clears on that edge, unless a new match occurs on the same edge; in that case the flag stays set.
- R10: Reading the flags register returns the following, and writes to it change nothing:
  - bit 7 is the watchdog interrupt input;
  - bit 6 is the alarm flag;
  - bit 4 is the battery-low input;
  - all other bits are 0.
- R11: When ft_bit is 1, the alarm enable is 0, and wdog_reg bit 7 is 1 or wdog_reg is 00h, irq_n follows clk512 (provided nothing else drives the pin low). Otherwise irq_n is 1 when nothing drives it.
- R12: A high wdog_irq forces irq_n to 0.
- R13: In battery mode, bus writes, reads and flag-clearing accesses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| tick_1hz | input | 1 | One-cycle pulse once per second, after the time fields update |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hours, BCD |
| now_date | input | 6 | Current day of month, BCD |
| wdog_irq | input | 1 | Watchdog interrupt request |
| wdog_reg | input | 8 | Current watchdog configuration byte |
| ft_bit | input | 1 | Frequency-test request bit |
| clk512 | input | 1 | 512 Hz square wave |
| batt_mode | input | 1 | Running from the backup battery |
| batt_low | input | 1 | Battery-low indication |
| bus_cyc | input | 1 | Host access in progress |
| bus_we | input | 1 | Host access is a write |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| irq_n | output | 1 | Active-low interrupt / frequency-test pin (1 = released) |

## Verification
The bound checker watches on every cycle that:
- reset clears the enables and the flag;
- the flag rises only after a tick and falls only after a flags access ended;
- a set and enabled flag, or a watchdog request, pulls the pin low;
- the battery-mode gate on the backup enable holds;
- battery mode freezes the enables.

The per-mask matching rates, the fallback for illegal masks, the flags read format, the set-beats-clear ordering and the 512 Hz pass-through conditions are shown only by the bench scenarios. These include randomised alarm and time patterns checked against a reference model.

// File: rtl/alm_pkg.sv
package alm_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 4;
    localparam int SEC_W  = 7;
    localparam int MIN_W  = 7;
    localparam int HR_W   = 6;
    localparam int DAY_W  = 6;
    localparam int N_ALM  = 4;

    localparam logic [ADDR_W-1:0] A_FLAGS = 4'h0;
    localparam logic [ADDR_W-1:0] A_ASEC  = 4'h2;
    localparam logic [ADDR_W-1:0] A_AMIN  = 4'h3;
    localparam logic [ADDR_W-1:0] A_AHR   = 4'h4;
    localparam logic [ADDR_W-1:0] A_ADAY  = 4'h5;
    localparam logic [ADDR_W-1:0] A_IEN   = 4'h6;

    localparam int B_WDF  = 7;
    localparam int B_AF   = 6;
    localparam int B_BLF  = 4;
    localparam int B_AE   = 7;
    localparam int B_ABE  = 5;
    localparam int B_MASK = 7;
    localparam int B_WDS  = 7;

    typedef enum logic [2:0] {
        RATE_TICK,
        RATE_S,
        RATE_MS,
        RATE_HMS,
        RATE_DHMS
    } rate_e;

    typedef struct packed {
        logic [DAY_W-1:0] day;
        logic [HR_W-1:0]  hr;
        logic [MIN_W-1:0] mn;
        logic [SEC_W-1:0] sec;
    } tod_t;

    // mask order: {day, hr, mn, sec}
    function automatic rate_e decode_rate(input logic [N_ALM-1:0] m);
        case (m)
            4'b1111: return RATE_TICK;
            4'b1110: return RATE_S;
            4'b1100: return RATE_MS;
            4'b1000: return RATE_HMS;
            4'b0000: return RATE_DHMS;
            default: return RATE_TICK;
        endcase
    endfunction
endpackage

// File: rtl/alm_regs.sv
module alm_regs
    import alm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              af,
    input  logic              blf,
    input  logic              wdf,
    output logic [REG_W-1:0]  rdata,
    output tod_t              alarm,
    output logic [N_ALM-1:0]  mask,
    output logic              ae,
    output logic              abe
);
    logic [REG_W-1:0] alm_q [N_ALM];
    logic [REG_W-1:0] ien_q;

    for (genvar g = 0; g < N_ALM; g++) begin : g_alm
        always_ff @(posedge clk) begin
            if (rst)
                alm_q[g] <= '0;
            else if (wr_en && addr == A_ASEC + ADDR_W'(g))
                alm_q[g] <= wdata;
        end
        assign mask[g] = alm_q[g][B_MASK];
    end

    always_ff @(posedge clk) begin
        if (rst)
            ien_q <= '0;
        else if (wr_en && addr == A_IEN)
            ien_q <= wdata;
    end

    assign alarm.sec = alm_q[0][SEC_W-1:0];
    assign alarm.mn  = alm_q[1][MIN_W-1:0];
    assign alarm.hr  = alm_q[2][HR_W-1:0];
    assign alarm.day = alm_q[3][DAY_W-1:0];
    assign ae        = ien_q[B_AE];
    assign abe       = ien_q[B_ABE];

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                A_FLAGS: begin
                    rdata[B_WDF] = wdf;
                    rdata[B_AF]  = af;
                    rdata[B_BLF] = blf;
                end
                A_ASEC:  rdata = alm_q[0];
                A_AMIN:  rdata = alm_q[1];
                A_AHR:   rdata = alm_q[2];
                A_ADAY:  rdata = alm_q[3];
                A_IEN:   rdata = ien_q;
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/alm_match.sv
module alm_match
    import alm_pkg::*;
(
    input  logic             tick,
    input  tod_t             now,
    input  tod_t             alarm,
    input  logic [N_ALM-1:0] mask,
    output logic             hit
);
    rate_e rate;
    logic  s_eq, m_eq, h_eq, d_eq;

    always_comb begin
        s_eq = (now.sec == alarm.sec);
        m_eq = (now.mn  == alarm.mn);
        h_eq = (now.hr  == alarm.hr);
        d_eq = (now.day == alarm.day);
        rate = decode_rate(mask);
        case (rate)
            RATE_TICK: hit = tick;
            RATE_S:    hit = tick && s_eq;
            RATE_MS:   hit = tick && s_eq && m_eq;
            RATE_HMS:  hit = tick && s_eq && m_eq && h_eq;
            RATE_DHMS: hit = tick && s_eq && m_eq && h_eq && d_eq;
            default:   hit = tick;
        endcase
    end
endmodule

// File: rtl/alm_pin.sv
module alm_pin
    import alm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic             bus_act,
    input  logic             flags_sel,
    input  logic             ae,
    input  logic             abe,
    input  logic             batt,
    input  logic             wdog_irq,
    input  logic             ft_bit,
    input  logic [REG_W-1:0] wdog_reg,
    input  logic             clk512,
    output logic             af,
    output logic             irq_n
);
    logic af_q, acc_q;
    logic flags_busy, acc_end, alarm_drv, ft_mode;

    assign flags_busy = bus_act && flags_sel;
    assign acc_end    = acc_q && !flags_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            af_q  <= 1'b0;
            acc_q <= 1'b0;
        end else begin
            acc_q <= flags_busy;
            if (hit)
                af_q <= 1'b1;          // a new match beats the clear
            else if (acc_end)
                af_q <= 1'b0;
        end
    end

    always_comb begin
        alarm_drv = af_q && ae && (!batt || abe) && !flags_busy && !acc_q;
        ft_mode   = ft_bit && !ae && (wdog_reg[B_WDS] || wdog_reg == '0);
        if (alarm_drv || wdog_irq)
            irq_n = 1'b0;
        else if (ft_mode)
            irq_n = clk512;
        else
            irq_n = 1'b1;
    end

    assign af = af_q;
endmodule

// File: rtl/alarm_irq_gen.sv
module alarm_irq_gen
    import alm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic [SEC_W-1:0]  now_sec,
    input  logic [MIN_W-1:0]  now_min,
    input  logic [HR_W-1:0]   now_hour,
    input  logic [DAY_W-1:0]  now_date,
    input  logic              wdog_irq,
    input  logic [REG_W-1:0]  wdog_reg,
    input  logic              ft_bit,
    input  logic              clk512,
    input  logic              batt_mode,
    input  logic              batt_low,
    input  logic              bus_cyc,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq_n
);
    logic             bus_act, wr_en, flags_sel, hit_w, af_w, ae_w, abe_w;
    logic [N_ALM-1:0] mask_w;
    tod_t             alarm_w, now_w;

    assign bus_act   = bus_cyc && !batt_mode;
    assign wr_en     = bus_act && bus_we;
    assign flags_sel = (bus_addr == A_FLAGS);
    assign now_w     = '{day: now_date, hr: now_hour, mn: now_min, sec: now_sec};

    alm_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(bus_act),
        .addr(bus_addr), .wdata(bus_wdata),
        .af(af_w), .blf(batt_low), .wdf(wdog_irq),
        .rdata(bus_rdata), .alarm(alarm_w), .mask(mask_w),
        .ae(ae_w), .abe(abe_w)
    );

    alm_match u_match (
        .tick(tick_1hz), .now(now_w), .alarm(alarm_w),
        .mask(mask_w), .hit(hit_w)
    );

    alm_pin u_pin (
        .clk(clk), .rst(rst), .hit(hit_w), .bus_act(bus_act),
        .flags_sel(flags_sel), .ae(ae_w), .abe(abe_w), .batt(batt_mode),
        .wdog_irq(wdog_irq), .ft_bit(ft_bit), .wdog_reg(wdog_reg),
        .clk512(clk512), .af(af_w), .irq_n(irq_n)
    );
endmodule

// File: rtl/alarm_irq_gen_chk.sv
module alarm_irq_gen_chk
    import alm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick_1hz,
    input logic              batt_mode,
    input logic              wdog_irq,
    input logic              ft_bit,
    input logic              bus_cyc,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              irq_n,
    input logic              af,
    input logic              ae,
    input logic              abe
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!ae && !abe && !af));

    a_r5_af_on_tick: assert property (@(posedge clk) disable iff (rst)
        ($rose(af) && !$past(rst)) |-> $past(tick_1hz));

    a_r7_alarm_drives: assert property (@(posedge clk) disable iff (rst)
        (af && ae && !batt_mode && !(bus_cyc && bus_addr == A_FLAGS)
         && !$past(bus_cyc && !batt_mode && bus_addr == A_FLAGS)) |-> !irq_n);

    a_r8_batt_needs_abe: assert property (@(posedge clk) disable iff (rst)
        (batt_mode && !abe && !wdog_irq && !ft_bit) |-> irq_n);

    a_r9_clear_after_access: assert property (@(posedge clk) disable iff (rst)
        ($fell(af) && !$past(rst)) |->
        ($past(bus_cyc, 2) && !$past(batt_mode, 2) && $past(bus_addr, 2) == A_FLAGS));

    a_r12_wdog_pulls_low: assert property (@(posedge clk) disable iff (rst)
        wdog_irq |-> !irq_n);

    a_r13_batt_freezes_enables: assert property (@(posedge clk) disable iff (rst)
        batt_mode |=> ($stable(ae) && $stable(abe)));
endmodule

bind alarm_irq_gen alarm_irq_gen_chk u_chk (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .batt_mode(batt_mode),
    .wdog_irq(wdog_irq), .ft_bit(ft_bit), .bus_cyc(bus_cyc),
    .bus_addr(bus_addr), .irq_n(irq_n), .af(af_w), .ae(ae_w), .abe(abe_w)
);

// File: tb/tb_alarm_irq_gen.sv
module tb_alarm_irq_gen;
    logic       clk = 1'b0;
    logic       rst, tick_1hz, wdog_irq, ft_bit, clk512, batt_mode, batt_low;
    logic       bus_cyc, bus_we, irq_n;
    logic [6:0] now_sec, now_min;
    logic [5:0] now_hour, now_date;
    logic [7:0] wdog_reg, bus_wdata, bus_rdata;
    logic [3:0] bus_addr;
    int         n_chk = 0, n_err = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    alarm_irq_gen dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); bus_cyc = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_cyc = 0; bus_we = 0;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); bus_cyc = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_cyc = 0;
        @(negedge clk);
    endtask

    task automatic do_tick(input logic [6:0] s, input logic [6:0] m,
                           input logic [5:0] h, input logic [5:0] dd);
        @(negedge clk); now_sec = s; now_min = m; now_hour = h; now_date = dd; tick_1hz = 1;
        @(negedge clk); tick_1hz = 0;
        #1;
    endtask

    task automatic set_alarm(input logic [3:0] mk, input logic [6:0] s, input logic [6:0] m,
                             input logic [5:0] h, input logic [5:0] dd);
        bus_write(4'h2, {mk[0], s});
        bus_write(4'h3, {mk[1], m});
        bus_write(4'h4, {mk[2], 1'b0, h});
        bus_write(4'h5, {mk[3], 1'b0, dd});
    endtask

    function automatic bit ref_hit(input logic [3:0] mk, input logic [6:0] as, am,
                                   input logic [5:0] ah, ad, input logic [6:0] s, m,
                                   input logic [5:0] h, dd);
        bit se = (s == as), me = (m == am), he = (h == ah), de = (dd == ad);
        case (mk)
            4'hF:    return 1'b1;
            4'hE:    return se;
            4'hC:    return se && me;
            4'h8:    return se && me && he;
            4'h0:    return se && me && he && de;
            default: return 1'b1;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [3:0] legal [5] = '{4'hF, 4'hE, 4'hC, 4'h8, 4'h0};
        void'($urandom(32'd4711));
        rst = 1; tick_1hz = 0; wdog_irq = 0; wdog_reg = 8'h00; ft_bit = 0; clk512 = 0;
        batt_mode = 0; batt_low = 0; bus_cyc = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        now_sec = 0; now_min = 0; now_hour = 0; now_date = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1 check("R1 irq_n after reset", irq_n, 1);
        bus_read(4'h6, rd); check("R1 enables reset", rd, 8'h00);
        bus_read(4'h2, rd); check("R1 alarm reg reset", rd, 8'h00);
        bus_read(4'h0, rd); check("R1 flag reset", rd, 8'h00);

        // R2 register access
        bus_write(4'h2, 8'hA5); bus_write(4'h3, 8'h5A); bus_write(4'h4, 8'h3C);
        bus_write(4'h5, 8'hC3); bus_write(4'h6, 8'h7F);
        bus_read(4'h2, rd); check("R2 reg2", rd, 8'hA5);
        bus_read(4'h3, rd); check("R2 reg3", rd, 8'h5A);
        bus_read(4'h4, rd); check("R2 reg4", rd, 8'h3C);
        bus_read(4'h5, rd); check("R2 reg5", rd, 8'hC3);
        bus_read(4'h6, rd); check("R2 reg6", rd, 8'h7F);
        bus_read(4'h9, rd); check("R2 unused addr", rd, 8'h00);
        bus_write(4'h6, 8'h00);

        // R10 flags format, read-only; R12 watchdog
        batt_low = 1;
        bus_write(4'h0, 8'hFF);
        bus_read(4'h0, rd); check("R10 flags blf, write ignored", rd, 8'h10);
        batt_low = 0; wdog_irq = 1;
        #1 check("R12 wdog pulls pin", irq_n, 0);
        bus_read(4'h0, rd); check("R10 flags wdf bit", rd, 8'h80);
        wdog_irq = 0;

        // R6 flag set with AE=0
        set_alarm(4'hF, 7'h00, 7'h00, 6'h00, 6'h00);
        do_tick(7'h11, 7'h22, 6'h13, 6'h14);
        check("R6 pin stays released", irq_n, 1);
        bus_read(4'h0, rd); check("R6 flag set with AE off", rd[6], 1);
        bus_read(4'h0, rd); check("R9 flag cleared by access", rd[6], 0);

        // R7 / R9 clear sequence
        bus_write(4'h6, 8'h80);
        repeat (4) @(negedge clk);
        #1 check("R5 no flag without tick", irq_n, 1);
        do_tick(7'h01, 7'h02, 6'h03, 6'h04);
        check("R7 alarm drives pin", irq_n, 0);
        @(negedge clk); bus_cyc = 1; bus_addr = 4'h0;
        #1 check("R9 released during access", irq_n, 1);
        @(negedge clk); bus_cyc = 0;
        #1 check("R9 released until clear edge", irq_n, 1);
        @(negedge clk);
        #1 check("R9 released after clear", irq_n, 1);

        // R9 set beats clear
        do_tick(7'h05, 7'h02, 6'h03, 6'h04);
        @(negedge clk); bus_cyc = 1; bus_addr = 4'h0;
        @(negedge clk); bus_cyc = 0; tick_1hz = 1;
        @(negedge clk); tick_1hz = 0;
        #1 check("R9 new match survives clear", irq_n, 0);
        bus_read(4'h0, rd); check("R9 flag kept", rd[6], 1);

        // R3 seconds-match, R4 illegal mask
        set_alarm(4'hE, 7'h15, 7'h30, 6'h12, 6'h25);
        do_tick(7'h16, 7'h30, 6'h12, 6'h25);
        check("R3 sec mismatch no alarm", irq_n, 1);
        do_tick(7'h15, 7'h31, 6'h11, 6'h24);
        check("R3 sec match alarm", irq_n, 0);
        bus_read(4'h0, rd);
        set_alarm(4'hA, 7'h15, 7'h30, 6'h12, 6'h25);
        do_tick(7'h40, 7'h41, 6'h02, 6'h03);
        check("R4 illegal mask fires", irq_n, 0);
        bus_read(4'h0, rd);

        // R8 battery gating, R13 bus ignored
        set_alarm(4'hF, 7'h0, 7'h0, 6'h0, 6'h0);
        bus_write(4'h6, 8'h80);
        batt_mode = 1;
        do_tick(7'h01, 7'h01, 6'h01, 6'h01);
        check("R8 no pin without ABE", irq_n, 1);
        batt_mode = 0;
        #1 check("R7 pin on leaving battery", irq_n, 0);
        bus_read(4'h0, rd);
        bus_write(4'h6, 8'hA0);
        batt_mode = 1;
        do_tick(7'h01, 7'h01, 6'h01, 6'h01);
        check("R8 pin with AE and ABE", irq_n, 0);
        bus_write(4'h6, 8'h00);
        bus_read(4'h0, rd);
        batt_mode = 0;
        bus_read(4'h6, rd); check("R13 write ignored in battery", rd, 8'hA0);
        bus_read(4'h0, rd); check("R13 clear ignored in battery", rd[6], 1);

        // R11 frequency test
        bus_write(4'h6, 8'h00);
        ft_bit = 1; wdog_reg = 8'h00; clk512 = 0;
        #1 check("R11 ft low phase", irq_n, 0);
        clk512 = 1;
        #1 check("R11 ft high phase", irq_n, 1);
        clk512 = 0; wdog_reg = 8'h05;
        #1 check("R11 ft off with watchdog armed", irq_n, 1);
        wdog_reg = 8'h85;
        #1 check("R11 ft on with steer bit", irq_n, 0);
        bus_write(4'h6, 8'h80);
        check("R11 ft off with AE", irq_n, 1);
        ft_bit = 0; wdog_reg = 8'h00;

        // R3 / R4 / R7 randomised
        for (int i = 0; i < 40; i++) begin
            logic [3:0] mk;
            logic [6:0] as, am, s, m;
            logic [5:0] ah, ad, h, dd;
            bit exp;
            int r = $urandom % 8;
            mk = (r < 5) ? legal[r] : 4'($urandom);
            as = 7'($urandom); am = 7'($urandom); ah = 6'($urandom); ad = 6'($urandom);
            s  = ($urandom % 2) ? as : 7'($urandom);
            m  = ($urandom % 2) ? am : 7'($urandom);
            h  = ($urandom % 2) ? ah : 6'($urandom);
            dd = ($urandom % 2) ? ad : 6'($urandom);
            set_alarm(mk, as, am, ah, ad);
            do_tick(s, m, h, dd);
            exp = ref_hit(mk, as, am, ah, ad, s, m, h, dd);
            check("R3 R4 R7 random pin", irq_n, !exp);
            bus_read(4'h0, rd);
            check("R3 R4 random flag", rd[6], exp);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule